// File: doc/BRIEF.md
# Arbitrated Atomic Memory Operation Unit

This block is a small word-addressed shared memory with several requester ports. A port can issue one of five operations: a plain read, a plain write, an atomic exchange, a test-and-set, or a fetch-and-increment. Every operation returns the value the word held before the operation. The three read-modify-write kinds are carried out as one indivisible pair: a read cycle followed by a write cycle. No other port is granted any access between the two cycles.

Software builds locks from these primitives. A lock word holding 0 is free and a word holding 1 is held. To acquire, a port exchanges (or test-and-sets) a 1 into the word, and a returned 0 means it now owns the lock. To release, a port does a plain write of 0. While a lock is busy, waiting ports can spin on plain reads, which never change the word. When several ports ask in the same cycle, a rotating-priority arbiter grants exactly one of them, so two simultaneous lock attempts on a free word always produce one winner and one loser.

Each port uses a valid/ready request handshake and has a one-entry response register. The response register holds the old value until the requester accepts it.

Top module: `atomic_mem_unit`

## Requirements
- R1: Exchange (op code 2) returns the word's previous value and stores the request data into the word.
- R2: Lock use: exchanging 1 into a word holding 0 returns 0 (acquired). Exchanging 1 into a word holding 1 returns 1 and leaves it 1 (already held).
- R3: At most one port is granted per cycle. When two ports exchange 1 into a free word in the same cycle, exactly one receives 0 and the other receives 1.
- R4: Fetch-and-increment (op code 4) returns the previous value and stores that value plus one, wrapping from all-ones to zero.
- R5: Test-and-set (op code 3) returns the previous value. It stores 1 only when that value was 0, leaves any nonzero word unchanged, and ignores the request data.
- R6: Plain write (op code 1) stores the request data and returns the previous value. Writing 0 releases a lock.
- R7: Plain read (op code 0) returns the word and leaves memory unchanged. Unused codes 5 to 7 behave as a plain read.
- R8: Among contending ports, the search for a winner starts at the port after the one granted most recently, wrapping from the last port to port 0.
- R9: In the cycle after a read-modify-write is granted, no port is granted. A request for the same word granted later sees the updated value.
- R10: A response is valid exactly one cycle after its grant. It holds a stable value until rsp_ready is high at a clock edge. A port with a pending response is not granted.
- R11: After reset, every memory word is 0 and no response is valid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NPORTS | Request present, one bit per port |
| req_ready | output | NPORTS | Request granted this cycle, one bit per port |
| req_op | input | NPORTS*3 | Operation code per port (0 read, 1 write, 2 exchange, 3 test-and-set, 4 fetch-and-increment) |
| req_addr | input | NPORTS*AW | Word address per port |
| req_wdata | input | NPORTS*DW | Write or exchange data per port |
| rsp_valid | output | NPORTS | Response present per port |
| rsp_ready | input | NPORTS | Requester accepts the response |
| rsp_rdata | output | NPORTS*DW | Previous word value per port |

## Verification
The assertions check every cycle that at most one grant is issued and that it goes only to a requesting, eligible port. They also check that no grant follows a read-modify-write grant, that a response appears in the cycle after its grant, and that a response holds while it is not accepted. Only the bench scenarios can show the data results. These are the value each operation returns, the value it leaves behind, the one-winner outcome of colliding lock attempts, the rotation of priority, and the ordering of a read queued behind an atomic increment. The bench checks these against a reference memory it keeps itself.

// File: rtl/atom_pkg.sv
package atom_pkg;
   localparam int OPW = 3;

   typedef enum logic [OPW-1:0] {
      OP_READ  = 3'd0,
      OP_WRITE = 3'd1,
      OP_XCHG  = 3'd2,
      OP_TAS   = 3'd3,
      OP_FINC  = 3'd4
   } atom_op_e;

   function automatic logic is_rmw(input logic [OPW-1:0] op);
      return (op == OP_XCHG) || (op == OP_TAS) || (op == OP_FINC);
   endfunction
endpackage

// File: rtl/atom_rr_arbiter.sv
module atom_rr_arbiter #(
   parameter int N = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] req,
   output logic [N-1:0] gnt
);
   localparam int PW = (N > 1) ? $clog2(N) : 1;

   logic [PW-1:0] ptr;
   logic [PW-1:0] win;
   logic          found;

   initial begin
      if (N < 1) $fatal(1, "atom_rr_arbiter: N must be at least 1");
   end

   always_comb begin
      gnt   = '0;
      found = 1'b0;
      win   = '0;
      for (int k = 0; k < N; k++) begin
         int idx;
         idx = (int'(ptr) + k) % N;
         if (!found && req[idx]) begin
            found    = 1'b1;
            gnt[idx] = 1'b1;
            win      = PW'(idx);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr <= '0;
      end else if (found) begin
         ptr <= (int'(win) == N - 1) ? '0 : win + PW'(1);
      end
   end

   p_gnt_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt));
   p_gnt_requested_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt & ~req) == '0);
   p_gnt_when_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (|req) |-> (|gnt));
endmodule

// File: rtl/atom_op_alu.sv
module atom_op_alu
   import atom_pkg::*;
#(
   parameter int DW = 16
) (
   input  logic [OPW-1:0] op,
   input  logic [DW-1:0]  old_val,
   input  logic [DW-1:0]  wdata,
   output logic           we,
   output logic [DW-1:0]  new_val
);
   always_comb begin
      we      = 1'b0;
      new_val = old_val;
      case (op)
         OP_WRITE, OP_XCHG: begin
            we      = 1'b1;
            new_val = wdata;
         end
         OP_TAS: begin
            we      = (old_val == '0);
            new_val = DW'(1);
         end
         OP_FINC: begin
            we      = 1'b1;
            new_val = old_val + DW'(1);
         end
         default: begin
            we      = 1'b0;
            new_val = old_val;
         end
      endcase
   end
endmodule

// File: rtl/atom_rsp_slot.sv
module atom_rsp_slot #(
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [DW-1:0] load_data,
   input  logic          rsp_ready,
   output logic          rsp_valid,
   output logic [DW-1:0] rsp_data
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_data  <= '0;
      end else if (load) begin
         rsp_valid <= 1'b1;
         rsp_data  <= load_data;
      end else if (rsp_valid && rsp_ready) begin
         rsp_valid <= 1'b0;
      end
   end

   p_rsp_after_grant_r10: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> rsp_valid);
   p_rsp_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));
   p_no_load_pending_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_ready) |-> !load);
endmodule

// File: rtl/atomic_mem_unit.sv
module atomic_mem_unit
   import atom_pkg::*;
#(
   parameter int NPORTS = 2,
   parameter int AW     = 4,
   parameter int DW     = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NPORTS-1:0]    req_valid,
   output logic [NPORTS-1:0]    req_ready,
   input  logic [NPORTS*3-1:0]  req_op,
   input  logic [NPORTS*AW-1:0] req_addr,
   input  logic [NPORTS*DW-1:0] req_wdata,
   output logic [NPORTS-1:0]    rsp_valid,
   input  logic [NPORTS-1:0]    rsp_ready,
   output logic [NPORTS*DW-1:0] rsp_rdata
);
   localparam int DEPTH = 1 << AW;

   initial begin
      if (NPORTS < 1) $fatal(1, "atomic_mem_unit: NPORTS must be at least 1");
      if (AW < 1 || AW > 10) $fatal(1, "atomic_mem_unit: AW out of range");
      if (DW < 2) $fatal(1, "atomic_mem_unit: DW must be at least 2");
   end

   logic [DW-1:0]     mem [DEPTH];
   logic              busy;
   logic [AW-1:0]     pend_addr;
   logic [DW-1:0]     pend_data;
   logic              pend_we;

   logic [NPORTS-1:0] elig;
   logic [NPORTS-1:0] gnt;
   logic              any_gnt;
   logic [OPW-1:0]    sel_op;
   logic [AW-1:0]     sel_addr;
   logic [DW-1:0]     sel_wdata;
   logic [DW-1:0]     old_val;
   logic              alu_we;
   logic [DW-1:0]     alu_new;
   logic              sel_rmw;

   assign elig      = req_valid & ~rsp_valid & {NPORTS{~busy}};
   assign req_ready = gnt;
   assign any_gnt   = |gnt;

   atom_rr_arbiter #(.N(NPORTS)) u_arb (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (elig),
      .gnt   (gnt)
   );

   always_comb begin
      sel_op    = '0;
      sel_addr  = '0;
      sel_wdata = '0;
      for (int p = 0; p < NPORTS; p++) begin
         if (gnt[p]) begin
            sel_op    = req_op[p*OPW +: OPW];
            sel_addr  = req_addr[p*AW +: AW];
            sel_wdata = req_wdata[p*DW +: DW];
         end
      end
   end

   assign old_val = mem[sel_addr];
   assign sel_rmw = is_rmw(sel_op);

   atom_op_alu #(.DW(DW)) u_alu (
      .op      (sel_op),
      .old_val (old_val),
      .wdata   (sel_wdata),
      .we      (alu_we),
      .new_val (alu_new)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy      <= 1'b0;
         pend_addr <= '0;
         pend_data <= '0;
         pend_we   <= 1'b0;
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (busy) begin
         if (pend_we) mem[pend_addr] <= pend_data;
         busy    <= 1'b0;
         pend_we <= 1'b0;
      end else if (any_gnt) begin
         if (sel_rmw) begin
            busy      <= 1'b1;
            pend_addr <= sel_addr;
            pend_data <= alu_new;
            pend_we   <= alu_we;
         end else if (alu_we) begin
            mem[sel_addr] <= alu_new;
         end
      end
   end

   for (genvar p = 0; p < NPORTS; p++) begin : g_port
      atom_rsp_slot #(.DW(DW)) u_slot (
         .clk       (clk),
         .rst_n     (rst_n),
         .load      (gnt[p]),
         .load_data (old_val),
         .rsp_ready (rsp_ready[p]),
         .rsp_valid (rsp_valid[p]),
         .rsp_data  (rsp_rdata[p*DW +: DW])
      );
   end

   p_rmw_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (any_gnt && sel_rmw) |=> (gnt == '0));
   p_busy_follows_rmw_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (any_gnt && sel_rmw) |=> busy);
endmodule

// File: tb/atomic_mem_unit_bench.sv
module atomic_mem_unit_bench;
   localparam int N  = 2;
   localparam int AW = 4;
   localparam int DW = 16;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [N-1:0]    req_valid = '0;
   logic [N-1:0]    req_ready;
   logic [N*3-1:0]  req_op = '0;
   logic [N*AW-1:0] req_addr = '0;
   logic [N*DW-1:0] req_wdata = '0;
   logic [N-1:0]    rsp_valid;
   logic [N-1:0]    rsp_ready = '1;
   logic [N*DW-1:0] rsp_rdata;

   int checks = 0;
   int errors = 0;
   bit done = 0;
   int last_gnt = -1;
   logic [DW-1:0] ref_mem [1<<AW];

   always #5 clk = ~clk;

   atomic_mem_unit #(.NPORTS(N), .AW(AW), .DW(DW)) u_atomic_mem_unit (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata));

   task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act,
                      input logic [DW-1:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] model_new(input int op, input logic [DW-1:0] old,
                                               input logic [DW-1:0] wd);
      case (op)
         1, 2:    return wd;
         3:       return (old == '0) ? DW'(1) : old;
         4:       return old + DW'(1);
         default: return old;
      endcase
   endfunction

   task automatic do_op(input int p, input int op, input int addr,
                        input logic [DW-1:0] wd, output logic [DW-1:0] rd);
      @(negedge clk);
      req_valid[p] = 1'b1;
      req_op[p*3 +: 3] = 3'(op);
      req_addr[p*AW +: AW] = AW'(addr);
      req_wdata[p*DW +: DW] = wd;
      #1;
      while (!req_ready[p]) begin
         @(negedge clk);
         #1;
      end
      last_gnt = p;
      @(negedge clk);
      req_valid[p] = 1'b0;
      chk(rsp_valid[p] === 1'b1, "R10 response one cycle after grant", DW'(rsp_valid[p]), 1);
      rd = rsp_rdata[p*DW +: DW];
   endtask

   task automatic ref_op(input int p, input int op, input int addr, input logic [DW-1:0] wd,
                         input string tag);
      logic [DW-1:0] rd, exp;
      exp = ref_mem[addr];
      do_op(p, op, addr, wd, rd);
      chk(rd === exp, tag, rd, exp);
      ref_mem[addr] = model_new(op, exp, wd);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [DW-1:0] r0, r1;
      int w, exp_w;
      void'($urandom(32'd1234));
      for (int i = 0; i < (1<<AW); i++) ref_mem[i] = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(rsp_valid === '0, "R11 no response after reset", DW'(rsp_valid), 0);
      rst_n = 1'b1;
      for (int i = 0; i < (1<<AW); i++) ref_op(i % N, 0, i, '0, "R11 memory zero after reset");

      ref_op(0, 2, 3, 16'h1234, "R1 exchange returns old");
      ref_op(1, 2, 3, 16'h00AB, "R1 exchange returned stored data");
      ref_op(0, 0, 3, '0, "R1 exchange stored data readback");

      ref_op(0, 2, 6, 16'h0001, "R2 lock acquire returns 0");
      ref_op(1, 2, 6, 16'h0001, "R2 held lock returns 1");
      ref_op(1, 0, 6, '0, "R2 held lock stays 1");
      ref_op(0, 1, 6, 16'h0000, "R6 release write returns old 1");
      ref_op(1, 0, 6, '0, "R6 released lock reads 0");

      ref_op(0, 3, 5, 16'h7777, "R5 tas on free returns 0");
      ref_op(1, 0, 5, '0, "R5 tas stored 1 ignoring data");
      ref_op(1, 1, 5, 16'h0042, "R6 write returns old");
      ref_op(0, 3, 5, 16'h0000, "R5 tas on nonzero returns old");
      ref_op(0, 0, 5, '0, "R5 tas left nonzero word unchanged");

      ref_op(1, 1, 7, 16'hFFFF, "R6 write setup");
      ref_op(0, 4, 7, '0, "R4 finc returns all-ones");
      ref_op(1, 0, 7, '0, "R4 finc wrapped to zero");
      ref_op(0, 4, 7, '0, "R4 finc returns zero");
      ref_op(0, 0, 7, '0, "R4 finc stored one");

      ref_op(1, 6, 7, 16'h5555, "R7 unused code reads");
      ref_op(0, 0, 7, '0, "R7 unused code left memory");

      for (int round = 0; round < 4; round++) begin
         ref_op(round % N, 1, 9, '0, "R6 release before contention");
         exp_w = (last_gnt + 1) % N;
         fork
            do_op(0, 2, 9, 16'h0001, r0);
            do_op(1, 2, 9, 16'h0001, r1);
         join
         chk((r0 == 0) != (r1 == 0), "R3 exactly one lock winner", r0, r1 ^ 16'h1);
         chk((r0 | r1) == 16'h1, "R3 loser sees held lock", r0 | r1, 1);
         w = (r0 == 0) ? 0 : 1;
         chk(w == exp_w, "R8 round-robin winner", DW'(w), DW'(exp_w));
         ref_mem[9] = 16'h1;
      end

      ref_op(1, 1, 10, 16'h0010, "R6 write setup");
      fork
         do_op(0, 4, 10, '0, r0);
         begin
            @(negedge clk);
            @(negedge clk);
            req_valid[1] = 1'b1;
            req_op[3 +: 3] = 3'd0;
            req_addr[AW +: AW] = AW'(10);
            #1;
            chk(req_ready[1] === 1'b0, "R9 no grant during atomic write cycle",
                DW'(req_ready[1]), 0);
            while (!req_ready[1]) begin @(negedge clk); #1; end
            @(negedge clk);
            req_valid[1] = 1'b0;
            r1 = rsp_rdata[DW +: DW];
         end
      join
      chk(r0 == 16'h0010, "R4 finc old under contention", r0, 16'h0010);
      chk(r1 == 16'h0011, "R9 later read sees increment", r1, 16'h0011);
      ref_mem[10] = 16'h0011;

      rsp_ready[0] = 1'b0;
      do_op(0, 0, 10, '0, r0);
      repeat (3) @(negedge clk);
      chk(rsp_valid[0] === 1'b1 && rsp_rdata[0 +: DW] == r0, "R10 response held",
          rsp_rdata[0 +: DW], r0);
      req_valid[0] = 1'b1;
      req_op[0 +: 3] = 3'd0;
      #1;
      chk(req_ready[0] === 1'b0, "R10 no grant while response pending", DW'(req_ready[0]), 0);
      req_valid[0] = 1'b0;
      rsp_ready[0] = 1'b1;
      @(negedge clk);
      chk(rsp_valid[0] === 1'b0, "R10 response cleared after accept", DW'(rsp_valid[0]), 0);

      for (int i = 0; i < 300; i++) begin
         int p, op, a;
         p  = $urandom_range(N-1);
         op = $urandom_range(6);
         a  = $urandom_range(3);
         ref_op(p, op, a, DW'($urandom), "R7 random op returns old value");
      end
      for (int i = 0; i < 4; i++) ref_op(0, 0, i, '0, "R7 random final contents");

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule